// File: doc/BRIEF.md
# Bank-Group Command Spacing Guard

This block sits beside a DRAM command scheduler and decides, on every clock, whether the command the scheduler is proposing may go out on that clock. It tracks the most recent column command (read or write) and the most recent row activate, and it demands a minimum gap before the next one. That gap is short when the new command targets a different bank group from the previous one, and long when both target the same group. It also keeps a rolling record of the last few activates and holds back any activate that would put too many of them inside one activation window.

The scheduler presents a command strobe, a command kind and a flat bank index. The bank group is the bank index divided by the number of banks in each group. `cmd_ok` is combinational from the proposal and the tracked state, so the scheduler can test a candidate before it commits to it. A command counts as issued when the strobe is high and `cmd_ok` is high. A strobe while `cmd_ok` is low is a protocol error. The guard flags it one cycle later and ignores the command. When the bank-group count parameter is zero, group identity is ignored and only the short spacings apply. All limits are parameters counted in clock cycles.

Top module: `dram_cmd_gate`

## Requirements
- R1: Kind code 0 (other: precharge, no-op and similar) always gives `cmd_ok` = 1. It never raises a violation and never changes any spacing or window state.
- R2: Out of reset, `cmd_violation` is 0, and both a first activate (kind 1) and a first column command (kind 2 read, kind 3 write) are allowed at once.
- R3: A column command whose bank group differs from that of the last issued column command is allowed only once at least CCD_S cycles (default 4) have passed since that command.
- R4: A column command in the same bank group as the last issued column command needs at least CCD_L cycles (default 6).
- R5: An activate in a bank group different from that of the last issued activate needs at least RRD_S cycles (default 4) since it.
- R6: An activate in the same bank group as the last issued activate needs at least RRD_L cycles (default 6).
- R7: Once ACT_LIMIT activates (default 4) have issued, a further activate is allowed only when the oldest of the last ACT_LIMIT activates is at least FAW cycles (default 26) in the past.
- R8: With NUM_GROUPS = 0, only CCD_S and RRD_S apply, whatever the bank index.
- R9: `cmd_violation` is high for exactly the one cycle that follows a clock edge at which `cmd_valid` was high while `cmd_ok` was low.
- R10: A blocked command changes no tracked state. Later decisions are the same as if that command had never been strobed.
- R11: The bank group is the bank index divided by NUM_BANKS/NUM_GROUPS, which is bits [3:2] with the defaults. Column and activate spacings are tracked independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | The proposed command is being issued this cycle |
| cmd_kind | input | 2 | 0 other, 1 activate, 2 read, 3 write |
| cmd_bank | input | $clog2(NUM_BANKS) | Flat bank index of the proposed command |
| cmd_ok | output | 1 | The proposed command may issue this cycle (combinational) |
| cmd_violation | output | 1 | One-cycle flag: a blocked command was strobed on the previous edge |

## Verification
`cmd_ok` is combinational, so it is due in the same cycle as the proposal. The bench drives each proposal just after a falling edge and samples `cmd_ok` a moment later, before the next rising edge. `cmd_violation` is registered and therefore due one cycle later. At each sample the bench compares it with the violation that its own model predicted for the previous cycle's stimulus. Spacing is counted in rising edges between the sample where a command issued and the sample that probes the next one. The directed probes therefore fall exactly on one cycle short of each limit and on the limit itself.

// File: rtl/dcg_pkg.sv
`timescale 1ns/1ps
package dcg_pkg;
    typedef enum logic [1:0] {
        CMD_OTHER = 2'd0,
        CMD_ACT   = 2'd1,
        CMD_RD    = 2'd2,
        CMD_WR    = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/dcg_gap_tracker.sv
`timescale 1ns/1ps
// Minimum-spacing tracker for one command class: remembers the age and
// bank group of the last issued command and picks the short or long limit.
module dcg_gap_tracker #(
    parameter int unsigned GROUPS = 4,
    parameter int unsigned SHORT  = 4,
    parameter int unsigned LONG   = 6,
    parameter int unsigned GRP_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] grp,
    input  logic             fire,
    output logic             ok
);
    localparam int unsigned MAXL = (LONG > SHORT) ? LONG : SHORT;
    localparam int unsigned AW   = $clog2(MAXL + 1);
    localparam logic [AW-1:0] SHORT_C = AW'(SHORT);
    localparam logic [AW-1:0] LONG_C  = AW'(LONG);
    localparam logic [AW-1:0] MAX_C   = AW'(MAXL);

    typedef struct packed {
        logic             seen;
        logic [GRP_W-1:0] grp;
        logic [AW-1:0]    age;
    } gap_st_t;

    gap_st_t     st_d, st_q;
    logic [AW-1:0] need;

    always_comb begin
        st_d = st_q;
        if (GROUPS != 0 && st_q.grp == grp) need = LONG_C;
        else                                 need = SHORT_C;
        ok = !st_q.seen || (st_q.age >= need);
        if (fire) begin
            st_d.seen = 1'b1;
            st_d.grp  = grp;
            st_d.age  = AW'(1);
        end else if (st_q.age != MAX_C) begin
            st_d.age = st_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dcg_act_window.sv
`timescale 1ns/1ps
// Rolling activation window: ring of per-activate ages; the slot under the
// write pointer is the oldest once the ring is full.
module dcg_act_window #(
    parameter int unsigned FAW       = 26,
    parameter int unsigned ACT_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic ok
);
    localparam int unsigned AW = $clog2(FAW + 1);
    localparam int unsigned PW = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;
    localparam logic [AW-1:0] FAW_C  = AW'(FAW);
    localparam logic [PW-1:0] LAST_P = PW'(ACT_LIMIT - 1);

    typedef struct packed {
        logic [ACT_LIMIT-1:0]         vld;
        logic [ACT_LIMIT-1:0][AW-1:0] age;
        logic [PW-1:0]                ptr;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [ACT_LIMIT-1:0] slot_open;

    for (genvar gi = 0; gi < ACT_LIMIT; gi++) begin : g_slot
        assign slot_open[gi] = !st_q.vld[gi] || (st_q.age[gi] >= FAW_C);
    end

    always_comb begin
        st_d = st_q;
        ok   = slot_open[st_q.ptr];
        for (int i = 0; i < ACT_LIMIT; i++) begin
            if (st_q.age[i] != FAW_C) st_d.age[i] = st_q.age[i] + 1'b1;
        end
        if (fire) begin
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.age[st_q.ptr] = AW'(1);
            st_d.ptr = (st_q.ptr == LAST_P) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dram_cmd_gate.sv
`timescale 1ns/1ps
module dram_cmd_gate #(
    parameter int unsigned NUM_BANKS  = 16,
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned CCD_S      = 4,
    parameter int unsigned CCD_L      = 6,
    parameter int unsigned RRD_S      = 4,
    parameter int unsigned RRD_L      = 6,
    parameter int unsigned FAW        = 26,
    parameter int unsigned ACT_LIMIT  = 4,
    localparam int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [BANK_W-1:0] cmd_bank,
    output logic              cmd_ok,
    output logic              cmd_violation
);
    import dcg_pkg::*;

    localparam int unsigned GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int unsigned G_DIV = (NUM_GROUPS > 0) ? NUM_GROUPS : 1;
    localparam int unsigned BPG   = (NUM_BANKS / G_DIV > 0) ? NUM_BANKS / G_DIV : 1;

    typedef struct packed {
        logic viol;
    } top_st_t;

    top_st_t          st_d, st_q;
    cmd_kind_e        kind;
    logic [GRP_W-1:0] grp;
    logic             is_act, is_cas;
    logic             cas_ok, rrd_ok, faw_ok;
    logic             fire_cas, fire_act;

    if (NUM_GROUPS > 0) begin : g_grouped
        logic [31:0] bank_ext;
        assign bank_ext = 32'(cmd_bank);
        assign grp      = GRP_W'(bank_ext / 32'(BPG));
    end else begin : g_flat
        assign grp = '0;
    end

    dcg_gap_tracker #(
        .GROUPS(NUM_GROUPS), .SHORT(CCD_S), .LONG(CCD_L), .GRP_W(GRP_W)
    ) u_cas_gap (
        .clk(clk), .rst_n(rst_n), .grp(grp), .fire(fire_cas), .ok(cas_ok)
    );

    dcg_gap_tracker #(
        .GROUPS(NUM_GROUPS), .SHORT(RRD_S), .LONG(RRD_L), .GRP_W(GRP_W)
    ) u_act_gap (
        .clk(clk), .rst_n(rst_n), .grp(grp), .fire(fire_act), .ok(rrd_ok)
    );

    dcg_act_window #(
        .FAW(FAW), .ACT_LIMIT(ACT_LIMIT)
    ) u_act_win (
        .clk(clk), .rst_n(rst_n), .fire(fire_act), .ok(faw_ok)
    );

    always_comb begin
        kind   = cmd_kind_e'(cmd_kind);
        is_act = (kind == CMD_ACT);
        is_cas = (kind == CMD_RD) || (kind == CMD_WR);
        if (is_act)      cmd_ok = rrd_ok && faw_ok;
        else if (is_cas) cmd_ok = cas_ok;
        else             cmd_ok = 1'b1;
        fire_cas = cmd_valid && is_cas && cas_ok;
        fire_act = cmd_valid && is_act && rrd_ok && faw_ok;
        st_d.viol = cmd_valid && !cmd_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_violation = st_q.viol;
endmodule

// File: rtl/dcg_checker.sv
`timescale 1ns/1ps
module dcg_checker #(
    parameter int unsigned NUM_BANKS  = 16,
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned CCD_S      = 4,
    parameter int unsigned CCD_L      = 6,
    parameter int unsigned RRD_S      = 4,
    parameter int unsigned RRD_L      = 6,
    localparam int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              cmd_ok,
    input logic              cmd_violation
);
    localparam int unsigned G_DIV = (NUM_GROUPS > 0) ? NUM_GROUPS : 1;
    localparam int unsigned BPG   = (NUM_BANKS / G_DIV > 0) ? NUM_BANKS / G_DIV : 1;
    localparam int unsigned SAT   = 1000;

    int unsigned cas_gap, act_gap, cas_grp, act_grp, grp_now;
    int unsigned cas_need, act_need;
    logic        cas_seen, act_seen, cas_prop, act_prop;

    always_comb begin
        grp_now  = (NUM_GROUPS == 0) ? 0 : (32'(cmd_bank) / BPG);
        cas_prop = (cmd_kind == 2'd2) || (cmd_kind == 2'd3);
        act_prop = (cmd_kind == 2'd1);
        cas_need = (NUM_GROUPS != 0 && grp_now == cas_grp) ? CCD_L : CCD_S;
        act_need = (NUM_GROUPS != 0 && grp_now == act_grp) ? RRD_L : RRD_S;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_gap <= 0; act_gap <= 0; cas_grp <= 0; act_grp <= 0;
            cas_seen <= 1'b0; act_seen <= 1'b0;
        end else begin
            if (cmd_valid && cmd_ok && cas_prop) begin
                cas_gap <= 1; cas_grp <= grp_now; cas_seen <= 1'b1;
            end else if (cas_gap < SAT) cas_gap <= cas_gap + 1;
            if (cmd_valid && cmd_ok && act_prop) begin
                act_gap <= 1; act_grp <= grp_now; act_seen <= 1'b1;
            end else if (act_gap < SAT) act_gap <= act_gap + 1;
        end
    end

    // R1
    a_r1_other_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == 2'd0) |-> cmd_ok);
    // R9
    a_r9_violation_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_violation |-> $past(cmd_valid && !cmd_ok));
    // R3, R4, R8
    a_r4_cas_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_prop && cmd_ok && cas_seen) |-> (cas_gap >= cas_need));
    // R5, R6, R8
    a_r6_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (act_prop && cmd_ok && act_seen) |-> (act_gap >= act_need));
endmodule

bind dram_cmd_gate dcg_checker #(
    .NUM_BANKS(NUM_BANKS), .NUM_GROUPS(NUM_GROUPS),
    .CCD_S(CCD_S), .CCD_L(CCD_L), .RRD_S(RRD_S), .RRD_L(RRD_L)
) u_dcg_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_ok(cmd_ok), .cmd_violation(cmd_violation)
);

// File: tb/tb_dram_cmd_gate.sv
`timescale 1ns/1ps
module tb_dram_cmd_gate;
    localparam logic [1:0] K_OTH = 2'd0, K_ACT = 2'd1, K_RD = 2'd2, K_WR = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid = 1'b0, f_valid = 1'b0;
    logic [1:0] kind = K_OTH, f_kind = K_OTH;
    logic [3:0] bank = '0, f_bank = '0;
    logic cmd_ok, cmd_violation, f_ok, f_viol;

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0, prev_viol = 1'b0;

    // bench model state
    int  cas_t, act_t, cas_g, act_g, act_cnt, act_ptr;
    bit  cas_seen, act_seen;
    int  hist [4];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    dram_cmd_gate dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(valid), .cmd_kind(kind),
        .cmd_bank(bank), .cmd_ok(cmd_ok), .cmd_violation(cmd_violation)
    );

    dram_cmd_gate #(.NUM_GROUPS(0)) dut_flat (
        .clk(clk), .rst_n(rst_n), .cmd_valid(f_valid), .cmd_kind(f_kind),
        .cmd_bank(f_bank), .cmd_ok(f_ok), .cmd_violation(f_viol)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit model_ok(input logic [1:0] k, input logic [3:0] b);
        int g = int'(b) / 4;
        if (k == K_OTH) return 1'b1;
        if (k == K_ACT) begin
            if (act_seen && (cyc - act_t) < ((g == act_g) ? 6 : 4)) return 1'b0;
            if (act_cnt >= 4 && (cyc - hist[act_ptr]) < 26) return 1'b0;
            return 1'b1;
        end
        if (cas_seen && (cyc - cas_t) < ((g == cas_g) ? 6 : 4)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_issue(input logic [1:0] k, input logic [3:0] b);
        int g = int'(b) / 4;
        if (k == K_ACT) begin
            act_seen = 1'b1; act_t = cyc; act_g = g;
            hist[act_ptr] = cyc;
            act_ptr = (act_ptr + 1) % 4;
            if (act_cnt < 4) act_cnt++;
        end else if (k == K_RD || k == K_WR) begin
            cas_seen = 1'b1; cas_t = cyc; cas_g = g;
        end
    endtask

    // exp < 0: model check only; otherwise also a directed expectation
    task automatic step(input logic v, input logic [1:0] k, input logic [3:0] b,
                        input int exp, input string tag);
        bit e;
        @(negedge clk);
        valid = v; kind = k; bank = b;
        #1;
        check("R9 violation flag", int'(cmd_violation), int'(prev_viol));
        e = model_ok(k, b);
        check({tag, " model"}, int'(cmd_ok), int'(e));
        if (exp >= 0) check({tag, " directed"}, int'(cmd_ok), exp);
        if (v && e) model_issue(k, b);
        prev_viol = v && !e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, K_OTH, 4'd0, -1, "idle R1");
    endtask

    task automatic fstep(input logic v, input logic [1:0] k, input logic [3:0] b,
                         input int exp, input string tag);
        @(negedge clk);
        f_valid = v; f_kind = k; f_bank = b;
        #1;
        if (exp >= 0) check(tag, int'(f_ok), exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cas_seen = 0; act_seen = 0; act_cnt = 0; act_ptr = 0;
        cas_t = 0; act_t = 0; cas_g = 0; act_g = 0;
        foreach (hist[i]) hist[i] = 0;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        @(negedge clk);
        valid = 0; kind = K_ACT; bank = 4'd0; #1;
        check("R2 violation after reset", int'(cmd_violation), 0);
        check("R2 first ACT allowed", int'(cmd_ok), 1);
        kind = K_WR; #1;
        check("R2 first CAS allowed", int'(cmd_ok), 1);
        kind = K_OTH;

        // R8 flat variant: same-group bank pairs only need short spacing
        fstep(1'b1, K_RD, 4'd0, 1, "R8 flat first RD");
        fstep(1'b0, K_RD, 4'd1, -1, "");
        fstep(1'b0, K_RD, 4'd1, -1, "");
        fstep(1'b0, K_RD, 4'd1, 0, "R8 flat CAS k=3");
        fstep(1'b0, K_RD, 4'd1, 1, "R8 flat CAS k=4");
        fstep(1'b1, K_ACT, 4'd2, 1, "R8 flat first ACT");
        fstep(1'b0, K_ACT, 4'd3, -1, "");
        fstep(1'b0, K_ACT, 4'd3, -1, "");
        fstep(1'b0, K_ACT, 4'd3, 0, "R8 flat ACT k=3");
        fstep(1'b0, K_ACT, 4'd3, 1, "R8 flat ACT k=4");
        fstep(1'b0, K_OTH, 4'd0, -1, "");

        // R3 / R4 / R11 column spacing
        step(1'b1, K_RD, 4'd0, 1, "R3 issue RD bank0");
        step(1'b0, K_RD, 4'd1, 0, "R4 same group k=1");
        step(1'b0, K_ACT, 4'd1, 1, "R11 ACT independent of CAS");
        step(1'b0, K_RD, 4'd4, 0, "R3 other group k=3");
        step(1'b0, K_RD, 4'd4, 1, "R3 other group k=4");
        step(1'b0, K_WR, 4'd1, 0, "R4 same group k=5");
        step(1'b0, K_WR, 4'd1, 1, "R4 same group k=6");

        // R9 / R10 / R1: blocked write leaves state untouched
        step(1'b1, K_RD, 4'd0, 1, "R10 issue RD bank0");
        step(1'b1, K_WR, 4'd1, 0, "R10 blocked WR");
        step(1'b1, K_OTH, 4'd5, 1, "R1 other while CAS blocked");
        step(1'b0, K_OTH, 4'd0, -1, "R9 gap");
        step(1'b0, K_WR, 4'd8, 1, "R10 k=4 after original RD");
        check("R1 no violation after other", int'(cmd_violation), 0);
        idle(10);

        // R5 / R6 activate spacing
        step(1'b1, K_ACT, 4'd0, 1, "R5 issue ACT bank0");
        step(1'b0, K_OTH, 4'd0, -1, "idle R1");
        step(1'b0, K_OTH, 4'd0, -1, "idle R1");
        step(1'b0, K_ACT, 4'd5, 0, "R5 other group k=3");
        step(1'b0, K_ACT, 4'd5, 1, "R5 other group k=4");
        step(1'b0, K_ACT, 4'd2, 0, "R6 same group k=5");
        step(1'b0, K_ACT, 4'd2, 1, "R6 same group k=6");
        idle(30);

        // R7 activation window
        for (int a = 0; a < 4; a++) begin
            step(1'b1, K_ACT, 4'(a * 4), 1, "R7 fill window");
            idle(3);
        end
        for (int k = 16; k < 26; k++) step(1'b0, K_ACT, 4'd1, 0, "R7 window full");
        step(1'b1, K_ACT, 4'd1, 1, "R7 window opens k=26");
        step(1'b0, K_OTH, 4'd0, -1, "idle R1");
        step(1'b0, K_OTH, 4'd0, -1, "idle R1");
        step(1'b0, K_ACT, 4'd5, 0, "R7 next slot k=29");
        step(1'b0, K_ACT, 4'd5, 1, "R7 next slot k=30");
        idle(30);

        // random mix against the bench model
        for (int i = 0; i < 5000; i++) begin
            logic v;
            logic [1:0] k;
            logic [3:0] b;
            v = ($urandom % 10) < 6;
            k = 2'($urandom % 4);
            b = 4'($urandom % 16);
            step(v, k, b, -1, "random R3 R4 R5 R6 R7 R10");
        end
        step(1'b0, K_OTH, 4'd0, -1, "final R9");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule